// File: doc/BRIEF.md
# Level-Source Interrupt Router With Claim Handshake

This block gathers level-sensitive interrupt lines from platform devices and presents, to each of several processor contexts, one request line plus a word-addressed register window. Software gives every source a small priority, chooses per context which sources it accepts and sets a per-context floor below which nothing is signalled. A context takes service of its best waiting source by reading its claim word and returns it by writing the same ID back.

Every source has a gateway. While a source is waiting, its bit is held in a pending register. Once a context claims it, the gateway closes: the input level is no longer sampled until the matching completion arrives. This keeps a still-asserted level line from raising a second request for an event that is already being handled. Each context has its own arbiter, which picks among the sources that are pending, enabled and above that context's floor.

The default build serves 31 sources (IDs 1 to 31) and two contexts. ID 0 is reserved and means "nothing".

Top module: `irqh_top`

## Requirements
- R1: After reset every priority, pending, enable and threshold register reads 0, both request outputs are low, and a claim read returns 0.
- R2: The priority of source n (1 ≤ n < NUM_SRC) is at byte address 4·n and holds 3 bits. Bits 31:3 read 0. A write to address 0 changes nothing, and address 0 reads 0.
- R3: The pending word at 0x1000 has bit n set while source n is waiting. Bit 0 always reads 0. Writes to this word are ignored.
- R4: The enable word of context c is at 0x2000 + 0x80·c, and bit n enables source n. Bit 0 is forced to 0. A request is raised only for enabled sources.
- R5: The threshold of context c is at 0x200000 + 0x1000·c and holds 3 bits. A source is signalled only when its priority is strictly greater than that threshold.
- R6: A read of the claim word (threshold address + 4) returns the ID of the source with the highest priority among those that are pending, enabled and above the threshold. On a priority tie the lower ID wins. If no source qualifies, the read returns 0.
- R7: A source whose priority is 0 is never returned by a claim and never raises a request.
- R8: A claim read that returns a nonzero ID clears that source's pending bit. From then on the source's input is ignored and its pending bit stays 0 until the source is completed.
- R9: Writing an ID to a context's claim word completes that source only if the source is enabled in that context. Otherwise the write has no effect.
- R10: Request output c is high exactly when a claim read of context c would return a nonzero ID.
- R11: Read data appears on the clock edge after the read strobe and holds until the next read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe; a claim read has side effects |
| rdata_o | output | 32 | Read data, registered |
| src_i | input | NUM_SRC | Level interrupt inputs, bit n is source n (bit 0 unused) |
| irq_o | output | NUM_CTX | Request line per context |

## Verification
The checker assumes that software never issues a read and a write to the same claim word in the same cycle, and that the address is held steady while a strobe is high. The bench drives one access per cycle and sets strobes and addresses only at falling edges, so it stays within these assumptions. Source levels change only between accesses, and the bench holds a line high across a claim so that the gateway's blocking can be seen in the pending word.

// File: rtl/irqh_pkg.sv
package irqh_pkg;

    // Register window offsets
    localparam int unsigned PEND_OFS   = 32'h0000_1000;
    localparam int unsigned EN_BASE    = 32'h0000_2000;
    localparam int unsigned EN_STRIDE  = 32'h0000_0080;
    localparam int unsigned CTX_BASE   = 32'h0020_0000;
    localparam int unsigned CTX_STRIDE = 32'h0000_1000;
    localparam int unsigned CLAIM_OFS  = 32'h0000_0004;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_THR,
        RG_CLAIM
    } region_e;

endpackage

// File: rtl/irqh_decode.sv
module irqh_decode
    import irqh_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CTX = 2,
    parameter int ADDR_W  = 24,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output region_e           kind_o,
    output logic [SRC_W-1:0]  src_o,
    output logic [CTX_W-1:0]  ctx_o
);

    localparam logic [9:0]        SRC_LIM  = 10'(NUM_SRC);
    localparam logic [4:0]        EN_LIM   = 5'(NUM_CTX);
    localparam logic [8:0]        CTX_LIM  = 9'(NUM_CTX);
    localparam logic [ADDR_W-1:0] PEND_A   = ADDR_W'(PEND_OFS);
    localparam logic [ADDR_W-13:0] EN_PAGE = (ADDR_W-12)'(EN_BASE >> 12);
    localparam logic [ADDR_W-22:0] CTX_PAGE = (ADDR_W-21)'(CTX_BASE >> 21);

    always_comb begin
        kind_o = RG_NONE;
        src_o  = '0;
        ctx_o  = '0;
        if (addr_i[ADDR_W-1:12] == '0) begin
            if (addr_i[1:0] == 2'b00 && addr_i[11:2] != '0 && addr_i[11:2] < SRC_LIM) begin
                kind_o = RG_PRIO;
                src_o  = addr_i[2 +: SRC_W];
            end
        end else if (addr_i == PEND_A) begin
            kind_o = RG_PEND;
        end else if (addr_i[ADDR_W-1:12] == EN_PAGE) begin
            if (addr_i[6:0] == '0 && addr_i[11:7] < EN_LIM) begin
                kind_o = RG_EN;
                ctx_o  = addr_i[7 +: CTX_W];
            end
        end else if (addr_i[ADDR_W-1:21] == CTX_PAGE && addr_i[20:12] < CTX_LIM) begin
            ctx_o = addr_i[12 +: CTX_W];
            if (addr_i[11:0] == 12'h000)
                kind_o = RG_THR;
            else if (addr_i[11:0] == 12'(CLAIM_OFS))
                kind_o = RG_CLAIM;
        end
    end

endmodule

// File: rtl/irqh_arbiter.sv
module irqh_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        cand_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         floor_i,
    output logic [SRC_W-1:0]          id_o
);

    logic [PRIO_W-1:0] best_p;

    // Ascending scan with strict compare: equal priority keeps the lower ID,
    // and the floor itself rejects anything not above the threshold.
    always_comb begin
        best_p = floor_i;
        id_o   = '0;
        for (int i = 1; i < NUM_SRC; i++) begin
            if (cand_i[i] && prio_i[i*PRIO_W +: PRIO_W] > best_p) begin
                best_p = prio_i[i*PRIO_W +: PRIO_W];
                id_o   = SRC_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqh_top.sv
module irqh_top
    import irqh_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 24,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               we_i,
    input  logic [31:0]        wdata_i,
    input  logic               re_i,
    output logic [31:0]        rdata_o,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_CTX-1:0] irq_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_SRC-1:0]             pend;
        logic [NUM_SRC-1:0]             busy;
        logic [NUM_CTX-1:0][NUM_SRC-1:0] en;
        logic [NUM_CTX-1:0][PRIO_W-1:0] thr;
        logic [31:0]                    rdata;
    } state_t;

    state_t st_d, st_q;

    region_e          kind;
    logic [SRC_W-1:0] sel_src;
    logic [CTX_W-1:0] sel_ctx;
    logic [NUM_CTX-1:0][SRC_W-1:0] win;
    logic [SRC_W-1:0] done_id;
    logic             done_ok;

    // Signals exposed for the bound checker
    logic [NUM_SRC-1:0]         pend_w;
    logic [NUM_SRC-1:0]         busy_w;
    logic [NUM_CTX*NUM_SRC-1:0] en_w;

    irqh_decode #(
        .NUM_SRC (NUM_SRC),
        .NUM_CTX (NUM_CTX),
        .ADDR_W  (ADDR_W)
    ) i_decode (
        .addr_i (addr_i),
        .kind_o (kind),
        .src_o  (sel_src),
        .ctx_o  (sel_ctx)
    );

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        irqh_arbiter #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W)
        ) i_arb (
            .cand_i  (st_q.pend & st_q.en[c]),
            .prio_i  (st_q.prio),
            .floor_i (st_q.thr[c]),
            .id_o    (win[c])
        );
        assign irq_o[c] = (win[c] != '0);
    end

    assign done_id = wdata_i[SRC_W-1:0];
    assign done_ok = (wdata_i < 32'(NUM_SRC)) && (done_id != '0)
                     && st_q.en[sel_ctx][done_id];

    always_comb begin
        st_d = st_q;

        // Gateways: an open gateway latches its level input as pending
        for (int i = 1; i < NUM_SRC; i++) begin
            if (src_i[i] && !st_q.busy[i])
                st_d.pend[i] = 1'b1;
        end

        if (re_i) begin
            unique case (kind)
                RG_PRIO:  st_d.rdata = 32'(st_q.prio[sel_src]);
                RG_PEND:  st_d.rdata = 32'(st_q.pend);
                RG_EN:    st_d.rdata = 32'(st_q.en[sel_ctx]);
                RG_THR:   st_d.rdata = 32'(st_q.thr[sel_ctx]);
                RG_CLAIM: begin
                    st_d.rdata = 32'(win[sel_ctx]);
                    if (win[sel_ctx] != '0) begin
                        st_d.pend[win[sel_ctx]] = 1'b0;
                        st_d.busy[win[sel_ctx]] = 1'b1;
                    end
                end
                default:  st_d.rdata = '0;
            endcase
        end

        if (we_i) begin
            unique case (kind)
                RG_PRIO:  st_d.prio[sel_src] = wdata_i[PRIO_W-1:0];
                RG_EN:    st_d.en[sel_ctx]   = wdata_i[NUM_SRC-1:0]
                                               & ~NUM_SRC'(1);
                RG_THR:   st_d.thr[sel_ctx]  = wdata_i[PRIO_W-1:0];
                RG_CLAIM: begin
                    if (done_ok)
                        st_d.busy[done_id] = 1'b0;
                end
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
    assign pend_w  = st_q.pend;
    assign busy_w  = st_q.busy;
    assign en_w    = st_q.en;

endmodule

// File: rtl/irqh_chk.sv
module irqh_chk
    import irqh_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CTX = 2,
    parameter int ADDR_W  = 24,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic [ADDR_W-1:0]          addr_i,
    input logic                       re_i,
    input logic [31:0]                rdata_o,
    input logic [NUM_CTX-1:0]         irq_o,
    input logic [NUM_SRC-1:0]         pend_i,
    input logic [NUM_SRC-1:0]         busy_i,
    input logic [NUM_CTX*NUM_SRC-1:0] en_i
);

    AST_PEND_BUSY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_i & busy_i) == '0); // R8

    AST_ID0_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pend_i[0] && !busy_i[0]); // R3

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        localparam logic [ADDR_W-1:0] CLM_A =
            ADDR_W'(CTX_BASE + c * CTX_STRIDE + CLAIM_OFS);

        AST_IDLE_CLAIM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
            re_i && addr_i == CLM_A && !irq_o[c] |=> rdata_o == '0); // R10

        AST_REQ_CLAIM_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
            re_i && addr_i == CLM_A && irq_o[c]
            |=> rdata_o != '0 && rdata_o < 32'(NUM_SRC)); // R6

        AST_CLAIM_CLOSES_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            re_i && addr_i == CLM_A && irq_o[c]
            |=> busy_i[rdata_o[SRC_W-1:0]] && !pend_i[rdata_o[SRC_W-1:0]]); // R8

        AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[c] |-> (pend_i & en_i[c*NUM_SRC +: NUM_SRC]) != '0); // R4
    end

endmodule

bind irqh_top irqh_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .ADDR_W  (ADDR_W)
) i_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .re_i    (re_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .pend_i  (pend_w),
    .busy_i  (busy_w),
    .en_i    (en_w)
);

// File: tb/test_irqh_top.sv
module test_irqh_top;

    localparam int NUM_SRC = 32;
    localparam int NUM_CTX = 2;
    localparam int ADDR_W  = 24;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic               we = 1'b0;
    logic [31:0]        wdata = '0;
    logic               re = 1'b0;
    logic [31:0]        rdata;
    logic [NUM_SRC-1:0] src = '0;
    logic [NUM_CTX-1:0] irq;
    logic               re_d = 1'b0;

    int checks = 0;
    int fails  = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk; // 50 MHz

    irqh_top #(
        .NUM_SRC (NUM_SRC),
        .NUM_CTX (NUM_CTX),
        .ADDR_W  (ADDR_W)
    ) i_irqh_top (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .addr_i  (addr),
        .we_i    (we),
        .wdata_i (wdata),
        .re_i    (re),
        .rdata_o (rdata),
        .src_i   (src),
        .irq_o   (irq)
    );

    function automatic logic [ADDR_W-1:0] a_prio(int n);  return ADDR_W'(4 * n); endfunction
    function automatic logic [ADDR_W-1:0] a_en(int c);    return ADDR_W'(32'h2000 + 32'h80 * c); endfunction
    function automatic logic [ADDR_W-1:0] a_thr(int c);   return ADDR_W'(32'h20_0000 + 32'h1000 * c); endfunction
    function automatic logic [ADDR_W-1:0] a_claim(int c); return ADDR_W'(32'h20_0004 + 32'h1000 * c); endfunction
    localparam logic [ADDR_W-1:0] A_PEND = 24'h00_1000;

    // Read-strobe delay line: read data is due one edge after the strobe (R11)
    always @(posedge clk) re_d <= rst_n & re;

    // Monitor: pops expected read data and compares
    always @(negedge clk) begin
        if (re_d) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R11: unexpected read data %h, expected none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    fails++;
                    $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        addr = a;
        re   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        re   = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic set_src(input logic [NUM_SRC-1:0] v);
        @(negedge clk);
        src = v;
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic [NUM_CTX-1:0] e, input string t);
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq actual %b expected %b", t, irq, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(a_prio(1), 32'h0, "R1");
        rd(A_PEND, 32'h0, "R1");
        rd(a_claim(0), 32'h0, "R1");
        chk_irq(2'b00, "R1");

        // R2: priority width and reserved source 0
        wr(a_prio(3), 32'hFF);
        rd(a_prio(3), 32'h7, "R2");
        wr(24'h0, 32'h5);
        rd(24'h0, 32'h0, "R2");

        // R3: pending reflects levels, bit 0 inert, read-only
        set_src(32'h0000_0009);
        rd(A_PEND, 32'h8, "R3");
        wr(A_PEND, 32'hFFFF_FFFF);
        rd(A_PEND, 32'h8, "R3");
        chk_irq(2'b00, "R10 not enabled");

        // R4: enable word, bit 0 forced low
        wr(a_en(0), 32'hFFFF_FFFF);
        rd(a_en(0), 32'hFFFF_FFFE, "R4");
        chk_irq(2'b01, "R10");

        // R5: threshold must be strictly exceeded
        wr(a_thr(0), 32'hF);
        rd(a_thr(0), 32'h7, "R5");
        chk_irq(2'b00, "R5");
        rd(a_claim(0), 32'h0, "R5");

        // R6/R7/R8: arbitration order and gateway closing
        wr(a_prio(5), 32'h7);
        wr(a_prio(9), 32'h2);
        set_src(32'h0000_1229);
        wr(a_thr(0), 32'h1);
        rd(a_claim(0), 32'd3, "R6 tie lower ID");
        rd(A_PEND, 32'h0000_1220, "R8 claimed bit cleared");
        rd(a_claim(0), 32'd5, "R6");
        rd(a_claim(0), 32'd9, "R6");
        rd(a_claim(0), 32'd0, "R7 zero priority");
        chk_irq(2'b00, "R7");
        rd(A_PEND, 32'h0000_1000, "R8 gated while high");

        // R9: complete from a context without the enable is ignored
        wr(a_claim(1), 32'd3);
        rd(A_PEND, 32'h0000_1000, "R9 ignored complete");
        wr(a_claim(0), 32'd3);
        rd(A_PEND, 32'h0000_1008, "R9 reopened");
        chk_irq(2'b01, "R10");

        // Second context
        wr(a_prio(12), 32'h4);
        wr(a_en(1), 32'h0000_1000);
        chk_irq(2'b11, "R10 both");
        rd(a_claim(1), 32'd12, "R6 ctx1");
        chk_irq(2'b01, "R10 after claim");

        // R11: unmapped addresses
        rd(24'h00_3000, 32'h0, "R11");
        rd(24'h20_0008, 32'h0, "R11");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R11: %0d reads unanswered, expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule